// File: doc/BRIEF.md
# Serial Bit-Rate Tick Selector

This block produces the bit-rate tick enables for a serial port. It holds a small control register, a reload-based bit-rate generator and three output selectors. The generator is an up-counter. It restarts from a programmable reload value each time it wraps, and it emits a one-cycle tick at every wrap. In fast mode it advances on every system clock. In slow mode a divide-by-six prescaler sits in front of it.

The transmit tick and the receive tick are selected separately. Each one comes either from the generator or from an external timer overflow strobe. A third selector feeds the synchronous shift mode, either from an external fixed-rate strobe or from the generator. The serial datapath that consumes these ticks is outside this block.

Top module: `baud_tick_sel`

## Requirements
- R1: After reset every control bit is 0. The generator is stopped, `tx_tick_o` and `rx_tick_o` follow `tmr_ovf_i`, and `shift_tick_o` follows `fixed_tick_i`.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i[4:0]` on that clock edge, with this bit mapping: bit 4 = run, bit 3 = transmit-from-generator, bit 2 = receive-from-generator, bit 1 = fast speed, bit 0 = shift-from-generator. Bits 7..5 have no effect.
- R3: While run is 0 the generator emits no tick, so any output routed to it stays low.
- R4: In fast mode (bit 1 = 1), consecutive generator ticks are exactly 256 − reload clock cycles apart.
- R5: In slow mode (bit 1 = 0), consecutive generator ticks are exactly 6 × (256 − reload) clock cycles apart.
- R6: `tx_tick_o` equals the generator tick when bit 3 is 1, and equals `tmr_ovf_i` when bit 3 is 0.
- R7: `rx_tick_o` equals the generator tick when bit 2 is 1, and equals `tmr_ovf_i` when bit 2 is 0, independently of bit 3.
- R8: `shift_tick_o` equals the generator tick when bit 0 is 1, and equals `fixed_tick_i` when bit 0 is 0. In the first case `fixed_tick_i` has no effect.
- R9: When run goes from 0 to 1, counting restarts from the reload value. The first tick is seen exactly one period (as defined in R4 or R5) after the clock edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control write data; only bits 4..0 are stored |
| reload_i | input | 8 | Generator reload value |
| tmr_ovf_i | input | 1 | External timer overflow strobe |
| fixed_tick_i | input | 1 | External fixed-rate strobe for shift mode |
| tx_tick_o | output | 1 | Transmit bit-rate tick |
| rx_tick_o | output | 1 | Receive bit-rate tick |
| shift_tick_o | output | 1 | Shift-mode bit-rate tick |

## Verification
The restart behaviour is the hardest to observe, because the counter value cannot be seen at the ports. The stimulus writes run high and then counts clock edges from the write edge until the first tick appears on a routed output. Comparing that count with the expected period in both speed modes shows that counting really began at the reload value and not at the held value. The stimulus also holds `fixed_tick_i` or `tmr_ovf_i` steadily high while measuring gaps on an output routed to the generator, which exposes any leakage through the selectors.

// File: rtl/btk_pkg.sv
package btk_pkg;
   localparam int CFG_W = 5;

   // Field order is fixed: bit 4 down to bit 0
   typedef struct packed {
      logic run;      // generator running
      logic tx_gen;   // transmit tick from generator
      logic rx_gen;   // receive tick from generator
      logic fast;     // no prescaler
      logic m0_gen;   // shift tick from generator
   } cfg_t;
endpackage

// File: rtl/btk_ctrl_reg.sv
module btk_ctrl_reg
   import btk_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output cfg_t              cfg_o
);
   if (DATA_W < CFG_W) begin : g_bad_width
      $error("btk_ctrl_reg: DATA_W must cover the control fields");
   end

   cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we_i) begin
         cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
      end
   end

   assign cfg_o = cfg_q;

   // R2
   cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (cfg_q == $past(wdata_i[CFG_W-1:0])));

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/btk_prescale.sv
module btk_prescale #(
   parameter int DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic en_i,
   output logic step_o
);
   if (DIV < 1) begin : g_bad_div
      $error("btk_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_bypass
      assign step_o = en_i;
   end else begin : g_divide
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (clear_i) begin
            pre_q <= '0;
         end else if (en_i) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end
      end

      assign step_o = en_i && (pre_q == LAST);

      // R5
      pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pre_q <= LAST);

      // R5
      pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clear_i |=> (pre_q == '0));
   end
endmodule

// File: rtl/btk_reload_ctr.sv
module btk_reload_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             start_o,
   output logic             tick_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("btk_reload_ctr: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             run_d_q;
   logic             start;
   logic             wrap;

   assign start = run_i && !run_d_q;
   assign wrap  = run_i && !start && step_i && (cnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_d_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         run_d_q <= run_i;
         if (start) begin
            cnt_q <= reload_i;
         end else if (run_i && step_i) begin
            cnt_q <= wrap ? reload_i : cnt_q + 1'b1;
         end
      end
   end

   assign start_o = start;
   assign tick_o  = wrap;

   // R3
   stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> !tick_o);

   // R3
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(cnt_q));

   // R9
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == $past(reload_i)));

   // R4
   wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/baud_tick_sel.sv
module baud_tick_sel
   import btk_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int DATA_W   = 8,
   parameter int SLOW_DIV = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic [CNT_W-1:0]  reload_i,
   input  logic              tmr_ovf_i,
   input  logic              fixed_tick_i,
   output logic              tx_tick_o,
   output logic              rx_tick_o,
   output logic              shift_tick_o
);
   cfg_t cfg;
   logic start;
   logic pre_step;
   logic step;
   logic gen_tick;

   btk_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .cfg_o   (cfg)
   );

   btk_prescale #(.DIV(SLOW_DIV)) pre_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start || !cfg.run || cfg.fast),
      .en_i    (cfg.run && !cfg.fast),
      .step_o  (pre_step)
   );

   assign step = cfg.fast ? 1'b1 : pre_step;

   btk_reload_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (cfg.run),
      .step_i   (step),
      .reload_i (reload_i),
      .start_o  (start),
      .tick_o   (gen_tick)
   );

   always_comb begin
      tx_tick_o    = cfg.tx_gen ? gen_tick : tmr_ovf_i;
      rx_tick_o    = cfg.rx_gen ? gen_tick : tmr_ovf_i;
      shift_tick_o = cfg.m0_gen ? gen_tick : fixed_tick_i;
   end

   // R8
   shift_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.m0_gen && !cfg.run) |-> !shift_tick_o);

   // R1
   reset_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg == '0) |-> (tx_tick_o == tmr_ovf_i && rx_tick_o == tmr_ovf_i));
endmodule

// File: tb/baud_tick_sel_tb_top.sv
module baud_tick_sel_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we_i = 1'b0;
   logic [7:0] cfg_wdata_i = '0;
   logic [7:0] reload_i = '0;
   logic       tmr_ovf_i = 1'b0;
   logic       fixed_tick_i = 1'b0;
   logic       tx_tick_o, rx_tick_o, shift_tick_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_tick_sel dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
      .reload_i(reload_i), .tmr_ovf_i(tmr_ovf_i), .fixed_tick_i(fixed_tick_i),
      .tx_tick_o(tx_tick_o), .rx_tick_o(rx_tick_o), .shift_tick_o(shift_tick_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic pick(input int which);
      case (which)
         0: return tx_tick_o;
         1: return rx_tick_o;
         default: return shift_tick_o;
      endcase
   endfunction

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      cfg_we_i = 1'b1;
      cfg_wdata_i = v;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   // edges from write edge to first tick on the chosen output
   task automatic latency(input int which, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!pick(which) && n < 5000);
   endtask

   // cycles between two consecutive ticks on the chosen output
   task automatic gap(input int which, output int n);
      int w = 0;
      while (!pick(which) && w < 5000) begin
         @(negedge clk);
         w++;
      end
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!pick(which) && n < 5000);
   endtask

   task automatic count_high(input int which, input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (pick(which)) n++;
      end
   endtask

   task automatic t_reset();
      int n;
      @(negedge clk);
      check("R1 tx idle", tx_tick_o, 0);
      check("R1 shift idle", shift_tick_o, 0);
      tmr_ovf_i = 1'b1;
      #1;
      check("R1 tx follows timer", tx_tick_o, 1);
      check("R1 rx follows timer", rx_tick_o, 1);
      check("R1 shift ignores timer", shift_tick_o, 0);
      tmr_ovf_i = 1'b0;
      fixed_tick_i = 1'b1;
      #1;
      check("R1 shift follows fixed", shift_tick_o, 1);
      check("R1 tx ignores fixed", tx_tick_o, 0);
      fixed_tick_i = 1'b0;
      count_high(0, 600, n);
      check("R1 generator stopped", n, 0);
   endtask

   task automatic t_fast();
      int n;
      reload_i = 8'd250;
      wr(8'h1A);
      latency(0, n);
      check("R9 fast first tick", n, 6);
      gap(0, n);
      check("R4 fast gap reload 250", n, 6);
      reload_i = 8'd200;
      gap(0, n);
      gap(0, n);
      check("R4 fast gap reload 200", n, 56);
      wr(8'h00);
   endtask

   task automatic t_slow();
      int n;
      reload_i = 8'd252;
      wr(8'h18);
      latency(0, n);
      check("R9 slow first tick", n, 24);
      gap(0, n);
      check("R5 slow gap reload 252", n, 24);
      reload_i = 8'd255;
      gap(0, n);
      gap(0, n);
      check("R5 slow gap reload 255", n, 6);
   endtask

   task automatic t_stop();
      int n;
      wr(8'h08);
      count_high(0, 500, n);
      check("R3 no tick while stopped", n, 0);
      @(negedge clk);
      tmr_ovf_i = 1'b1;
      #1;
      check("R6 tx ignores timer when generator chosen", tx_tick_o, 0);
      check("R7 rx follows timer", rx_tick_o, 1);
      tmr_ovf_i = 1'b0;
   endtask

   task automatic t_indep();
      int n;
      reload_i = 8'd246;
      wr(8'h16);
      latency(1, n);
      check("R7 rx first tick", n, 10);
      gap(1, n);
      check("R7 rx gap", n, 10);
      count_high(0, 100, n);
      check("R6 tx quiet with timer low", n, 0);
      @(negedge clk);
      tmr_ovf_i = 1'b1;
      #1;
      check("R6 tx follows timer", tx_tick_o, 1);
      tmr_ovf_i = 1'b0;
      wr(8'h00);
   endtask

   task automatic t_shift();
      int n;
      reload_i = 8'd240;
      wr(8'h13);
      fixed_tick_i = 1'b1;
      latency(2, n);
      check("R8 shift first tick", n, 16);
      gap(2, n);
      check("R8 shift gap with fixed high", n, 16);
      count_high(2, 64, n);
      check("R8 shift tick count", n, 4);
      fixed_tick_i = 1'b0;
      wr(8'h00);
   endtask

   task automatic t_upper();
      int n;
      reload_i = 8'd251;
      wr(8'hFA);
      latency(0, n);
      check("R2 upper bits ignored first tick", n, 5);
      gap(0, n);
      check("R2 upper bits ignored gap", n, 5);
      wr(8'hE0);
      count_high(0, 50, n);
      check("R2 upper-only write stops", n, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fast();
      t_slow();
      t_stop();
      t_indep();
      t_shift();
      t_upper();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule